// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane Display Sequencer

This block produces the timing of one color frame for a spatial light modulator whose pixels can only be fully on or fully off. At each frame-start pulse it divides the programmed frame period into three consecutive color slots: red, then green, then blue. The length of each slot is a programmable percentage of the frame. Each slot is then cut into eight bit-plane intervals. The interval for bit k lasts 2^k weight units, so that the on-time of a pixel reproduces the binary value of its color component.

The block carries no pixel data. For every bit-plane it reports the active color and bit index. It pulses a load strobe so that a downstream fetch engine can bring in that plane, and it enables the LED of the active color. A camera trigger rises at the start of each slot's first bit-plane and stays high for a programmable number of cycles. New settings are sampled only at a frame start. A frame start that arrives in the middle of a frame restarts the sequence at once.

Top module: `bpl_seq_top`

## Requirements
- R1: After reset, and until the first frame start, every output is low: color_idx 0, bit_idx 0, plane_valid 0, load_strobe 0, led_en 0, trigger 0.
- R2: Slot length is floor(frame_cycles × share / 100). The slots run red (color_idx 0), green (1), blue (2), and a slot of length zero is skipped. Once the blue slot ends, all outputs stay low until the next frame start.
- R3: The weight unit is floor(slot_length / 255). Bit k occupies unit × 2^k cycles, and the bits run from 0 up to 7 starting at the first cycle of the slot. The remaining cycles of the slot are idle, with plane_valid 0 and bit_idx 0.
- R4: When the weight unit of a slot is zero, the whole slot is idle. It produces no strobe, no LED enable and no trigger, while color_idx still shows the slot's color.
- R5: load_strobe is high for exactly the first cycle of each bit-plane interval.
- R6: During a bit-plane interval, led_en has only bit color_idx set. In idle cycles and outside a frame, led_en is 0.
- R7: trigger is high for trig_len cycles, starting in the first cycle of bit 0 of each slot. A trig_len of 0 produces no trigger.
- R8: Changes to the configuration inputs during a frame have no effect until the next frame start.
- R9: A frame start resynchronizes the sequence. In the next cycle the block shows bit 0 of the first slot of nonzero length, whatever position it was at before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame and samples the configuration |
| cfg_frame_cycles | input | CNT_W | Frame period in clock cycles |
| cfg_share_r | input | PCT_W | Red share of the frame in percent |
| cfg_share_g | input | PCT_W | Green share of the frame in percent |
| cfg_share_b | input | PCT_W | Blue share of the frame in percent |
| cfg_trig_len | input | TRIG_W | Trigger pulse length in cycles |
| color_idx | output | 2 | Active color: 0 red, 1 green, 2 blue |
| bit_idx | output | BI_W | Active bit-plane index |
| plane_valid | output | 1 | High while a bit-plane is being displayed |
| load_strobe | output | 1 | One-cycle pulse at the start of each bit-plane |
| led_en | output | 3 | Per-color LED enable, bit n for color n |
| trigger | output | 1 | Camera trigger |

## Verification
The bench varies the weight unit across slots and chooses slot lengths that leave an idle remainder, so an off-by-one in the plane boundaries would shift every strobe and bit index after bit 0. It also covers a zero-share slot that must be skipped and a slot shorter than 255 cycles that must stay dark. A design that miscounted either case would light an LED or strobe during the idle slot, or it would show the wrong color. Configuration is changed in the middle of a frame, and a frame start is issued in the middle of a frame. A block that applied settings at once would stretch or shrink the slots that follow. A block that ignored the resync would carry on with its old position. A zero trigger length checks that no stray one-cycle pulse appears.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  localparam int NUM_COLORS  = 3;
  localparam int COLOR_IDX_W = 2;
  localparam int PCT_FULL    = 100;

  typedef enum logic [COLOR_IDX_W-1:0] {
    CLR_RED   = 2'd0,
    CLR_GREEN = 2'd1,
    CLR_BLUE  = 2'd2
  } color_e;
endpackage

// File: rtl/bpl_cfg_shadow.sv
module bpl_cfg_shadow
  import bpl_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int PCT_W     = 7,
  parameter int TRIG_W    = 8,
  parameter int BIT_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_start,
  input  logic [CNT_W-1:0]                 frame_cycles,
  input  logic [NUM_COLORS-1:0][PCT_W-1:0] shares,
  input  logic [TRIG_W-1:0]                trig_len,
  output logic [NUM_COLORS-1:0][CNT_W-1:0] nxt_len,
  output logic [NUM_COLORS-1:0][CNT_W-1:0] nxt_unit,
  output logic [NUM_COLORS-1:0][CNT_W-1:0] cur_len,
  output logic [NUM_COLORS-1:0][CNT_W-1:0] cur_unit,
  output logic [TRIG_W-1:0]                cur_trig_len
);
  localparam int PW = CNT_W + PCT_W;
  localparam logic [PW-1:0]    PCT_DIV = PW'(PCT_FULL);
  localparam logic [CNT_W-1:0] WSUM    = CNT_W'((1 << BIT_DEPTH) - 1);

  // Slot length: floor(frame * share / 100)
  function automatic logic [CNT_W-1:0] slot_cycles(input logic [CNT_W-1:0] f,
                                                   input logic [PCT_W-1:0] s);
    logic [PW-1:0] prod;
    prod = PW'(f) * PW'(s);
    return CNT_W'(prod / PCT_DIV);
  endfunction

  // Weight unit: floor(slot / (2^depth - 1))
  function automatic logic [CNT_W-1:0] plane_unit(input logic [CNT_W-1:0] slot);
    return slot / WSUM;
  endfunction

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_calc
    assign nxt_len[c]  = slot_cycles(frame_cycles, shares[c]);
    assign nxt_unit[c] = plane_unit(nxt_len[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_len      <= '0;
      cur_unit     <= '0;
      cur_trig_len <= '0;
    end else if (frame_start) begin
      cur_len      <= nxt_len;
      cur_unit     <= nxt_unit;
      cur_trig_len <= trig_len;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_len) && $stable(cur_unit) && $stable(cur_trig_len))); // R8
endmodule

// File: rtl/bpl_plane_seq.sv
module bpl_plane_seq
  import bpl_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int BIT_DEPTH = 8,
  localparam int BI_W     = $clog2(BIT_DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_start,
  input  logic [NUM_COLORS-1:0][CNT_W-1:0] nxt_len,
  input  logic [NUM_COLORS-1:0][CNT_W-1:0] nxt_unit,
  input  logic [NUM_COLORS-1:0][CNT_W-1:0] cur_len,
  input  logic [NUM_COLORS-1:0][CNT_W-1:0] cur_unit,
  output logic [COLOR_IDX_W-1:0]           color_idx,
  output logic [BI_W-1:0]                  bit_idx,
  output logic                             plane_valid,
  output logic                             load_strobe,
  output logic [NUM_COLORS-1:0]            led_en,
  output logic                             slot_start
);
  localparam logic [BI_W:0] BIT_IDLE = (BI_W+1)'(BIT_DEPTH);

  logic                   active_q;
  logic [COLOR_IDX_W-1:0] color_q;
  logic [BI_W:0]          bit_q;
  logic [CNT_W-1:0]       pcnt_q;
  logic [CNT_W-1:0]       scnt_q;

  // Returns {found, index} of first color at or after 'from' with nonzero length
  function automatic logic [COLOR_IDX_W:0] scan_from(
      input logic [NUM_COLORS-1:0][CNT_W-1:0] lens, input int from);
    logic                   found;
    logic [COLOR_IDX_W-1:0] idx;
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_COLORS; i++) begin
      if (!found && i >= from && lens[i] != '0) begin
        found = 1'b1;
        idx   = COLOR_IDX_W'(i);
      end
    end
    return {found, idx};
  endfunction

  logic [COLOR_IDX_W:0] first_hit, next_hit;
  logic [CNT_W-1:0]     plane_len, plane_last, slot_last;
  logic                 in_plane, slot_end, plane_end;

  assign first_hit  = scan_from(nxt_len, 0);
  assign next_hit   = scan_from(cur_len, int'(color_q) + 1);
  assign plane_len  = cur_unit[color_q] << bit_q;
  assign plane_last = plane_len - CNT_W'(1);
  assign slot_last  = cur_len[color_q] - CNT_W'(1);
  assign in_plane   = active_q && (bit_q < BIT_IDLE);
  assign slot_end   = active_q && (scnt_q == slot_last);
  assign plane_end  = in_plane && (pcnt_q == plane_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      color_q  <= '0;
      bit_q    <= BIT_IDLE;
      pcnt_q   <= '0;
      scnt_q   <= '0;
    end else if (frame_start) begin
      active_q <= first_hit[COLOR_IDX_W];
      color_q  <= first_hit[COLOR_IDX_W-1:0];
      bit_q    <= (nxt_unit[first_hit[COLOR_IDX_W-1:0]] == '0) ? BIT_IDLE : '0;
      pcnt_q   <= '0;
      scnt_q   <= '0;
    end else if (slot_end) begin
      pcnt_q <= '0;
      scnt_q <= '0;
      if (next_hit[COLOR_IDX_W]) begin
        color_q <= next_hit[COLOR_IDX_W-1:0];
        bit_q   <= (cur_unit[next_hit[COLOR_IDX_W-1:0]] == '0) ? BIT_IDLE : '0;
      end else begin
        active_q <= 1'b0;
        color_q  <= '0;
        bit_q    <= BIT_IDLE;
      end
    end else if (active_q) begin
      scnt_q <= scnt_q + CNT_W'(1);
      if (plane_end) begin
        pcnt_q <= '0;
        bit_q  <= bit_q + (BI_W+1)'(1);
      end else if (in_plane) begin
        pcnt_q <= pcnt_q + CNT_W'(1);
      end
    end
  end

  assign color_idx   = active_q ? color_q : '0;
  assign bit_idx     = in_plane ? bit_q[BI_W-1:0] : '0;
  assign plane_valid = in_plane;
  assign load_strobe = in_plane && (pcnt_q == '0);
  assign slot_start  = load_strobe && (bit_q == '0);

  for (genvar c = 0; c < NUM_COLORS; c++) begin : g_led
    assign led_en[c] = in_plane && (color_q == COLOR_IDX_W'(c));
  end

  AST_COLOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(frame_start) && color_q != $past(color_q))
      |-> (color_q > $past(color_q))); // R2
  AST_PLANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && bit_idx != '0)
      |-> ($past(plane_valid) && BI_W'($past(bit_idx) + 1'b1) == bit_idx)); // R3
endmodule

// File: rtl/bpl_trig_gen.sv
module bpl_trig_gen #(
  parameter int TRIG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic [TRIG_W-1:0] trig_len,
  output logic              trigger
);
  logic [TRIG_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (slot_start) begin
      rem_q <= (trig_len == '0) ? '0 : trig_len - TRIG_W'(1);
    end else if (rem_q != '0) begin
      rem_q <= rem_q - TRIG_W'(1);
    end
  end

  assign trigger = (slot_start && trig_len != '0) || (rem_q != '0);

  AST_TRIG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trigger) |-> slot_start); // R7
  AST_TRIG_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && !slot_start) |-> $past(trigger)); // R7
endmodule

// File: rtl/bpl_seq_top.sv
module bpl_seq_top
  import bpl_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int PCT_W     = 7,
  parameter int TRIG_W    = 8,
  parameter int BIT_DEPTH = 8,
  localparam int BI_W     = $clog2(BIT_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic [CNT_W-1:0]       cfg_frame_cycles,
  input  logic [PCT_W-1:0]       cfg_share_r,
  input  logic [PCT_W-1:0]       cfg_share_g,
  input  logic [PCT_W-1:0]       cfg_share_b,
  input  logic [TRIG_W-1:0]      cfg_trig_len,
  output logic [COLOR_IDX_W-1:0] color_idx,
  output logic [BI_W-1:0]        bit_idx,
  output logic                   plane_valid,
  output logic                   load_strobe,
  output logic [NUM_COLORS-1:0]  led_en,
  output logic                   trigger
);
  logic [NUM_COLORS-1:0][PCT_W-1:0] shares;
  logic [NUM_COLORS-1:0][CNT_W-1:0] nxt_len, nxt_unit, cur_len, cur_unit;
  logic [TRIG_W-1:0]                cur_trig_len;
  logic                             slot_start;

  assign shares[int'(CLR_RED)]   = cfg_share_r;
  assign shares[int'(CLR_GREEN)] = cfg_share_g;
  assign shares[int'(CLR_BLUE)]  = cfg_share_b;

  bpl_cfg_shadow #(
    .CNT_W(CNT_W), .PCT_W(PCT_W), .TRIG_W(TRIG_W), .BIT_DEPTH(BIT_DEPTH)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_cycles(cfg_frame_cycles), .shares(shares), .trig_len(cfg_trig_len),
    .nxt_len(nxt_len), .nxt_unit(nxt_unit),
    .cur_len(cur_len), .cur_unit(cur_unit), .cur_trig_len(cur_trig_len)
  );

  bpl_plane_seq #(
    .CNT_W(CNT_W), .BIT_DEPTH(BIT_DEPTH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .nxt_len(nxt_len), .nxt_unit(nxt_unit),
    .cur_len(cur_len), .cur_unit(cur_unit),
    .color_idx(color_idx), .bit_idx(bit_idx), .plane_valid(plane_valid),
    .load_strobe(load_strobe), .led_en(led_en), .slot_start(slot_start)
  );

  bpl_trig_gen #(
    .TRIG_W(TRIG_W)
  ) u_trig (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .trig_len(cur_trig_len), .trigger(trigger)
  );

  AST_LED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|led_en) |-> (load_strobe && bit_idx == '0)); // R6
  AST_LED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    plane_valid |-> (led_en[color_idx] && $countones(led_en) == 1)); // R6
endmodule

// File: tb/bpl_seq_top_test.sv
module bpl_seq_top_test;
  typedef struct packed {
    logic [23:0] fc;
    logic [6:0]  sr, sg, sb;
    logic [7:0]  tl;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{fc: 24'd3000, sr: 7'd40, sg: 7'd45, sb: 7'd15, tl: 8'd3},
    '{fc: 24'd2600, sr: 7'd10, sg: 7'd80, sb: 7'd10, tl: 8'd1},
    '{fc: 24'd1000, sr: 7'd0,  sg: 7'd60, sb: 7'd40, tl: 8'd5},
    '{fc: 24'd1200, sr: 7'd20, sg: 7'd50, sb: 7'd30, tl: 8'd0},
    '{fc: 24'd5100, sr: 7'd33, sg: 7'd33, sb: 7'd34, tl: 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [23:0] cfg_frame_cycles = '0;
  logic [6:0]  cfg_share_r = '0, cfg_share_g = '0, cfg_share_b = '0;
  logic [7:0]  cfg_trig_len = '0;
  logic [1:0]  color_idx;
  logic [2:0]  bit_idx;
  logic        plane_valid, load_strobe, trigger;
  logic [2:0]  led_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10ns clk = ~clk;

  bpl_seq_top uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_frame_cycles(cfg_frame_cycles), .cfg_share_r(cfg_share_r),
    .cfg_share_g(cfg_share_g), .cfg_share_b(cfg_share_b),
    .cfg_trig_len(cfg_trig_len), .color_idx(color_idx), .bit_idx(bit_idx),
    .plane_valid(plane_valid), .load_strobe(load_strobe), .led_en(led_en),
    .trigger(trigger)
  );

  task automatic chk(input bit ok, input string ctx, input string tag,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", ctx, tag, act, exp, $time);
    end
  endtask

  // Walks one frame; expectations come from slot positions, not counters
  task automatic run_frame(input vec_t v, input int obs, input int chg_at, input string ctx);
    int len [3];
    int unit [3];
    int shr [3];
    shr[0] = int'(v.sr); shr[1] = int'(v.sg); shr[2] = int'(v.sb);
    for (int c = 0; c < 3; c++) begin
      len[c]  = int'(v.fc) * shr[c] / 100;
      unit[c] = len[c] / 255;
    end
    @(negedge clk);
    cfg_frame_cycles = v.fc;
    cfg_share_r = v.sr; cfg_share_g = v.sg; cfg_share_b = v.sb;
    cfg_trig_len = v.tl;
    frame_start = 1'b1;
    for (int t = 0; t < obs; t++) begin
      int base, ecol, ebit, p, uc;
      bit eact, evalid, estr, etrig;
      string utag;
      @(negedge clk);
      frame_start = 1'b0;
      base = 0; eact = 0; ecol = 0; ebit = 0; evalid = 0; estr = 0; etrig = 0;
      uc = 1;
      for (int c = 0; c < 3; c++) begin
        if (!eact && t >= base && t < base + len[c]) begin
          eact = 1; ecol = c; p = t - base; uc = unit[c];
          if (unit[c] > 0) begin
            for (int k = 0; k < 8; k++) begin
              int lo, hi;
              lo = unit[c] * ((1 << k) - 1);
              hi = unit[c] * ((1 << (k + 1)) - 1);
              if (p >= lo && p < hi) begin
                evalid = 1; ebit = k; estr = (p == lo);
              end
            end
            etrig = (p < int'(v.tl));
          end
        end
        base += len[c];
      end
      utag = (eact && uc == 0) ? "R4" : "";
      chk(int'(color_idx) == ecol, ctx, {"R2 color ", utag}, int'(color_idx), ecol);
      chk(plane_valid == evalid && int'(bit_idx) == ebit, ctx, {"R3 bit ", utag},
          int'(bit_idx) + 16 * int'(plane_valid), ebit + 16 * int'(evalid));
      chk(load_strobe == estr, ctx, {"R5 strobe ", utag}, int'(load_strobe), int'(estr));
      chk(int'(led_en) == (evalid ? (1 << ecol) : 0), ctx, {"R6 led ", utag},
          int'(led_en), evalid ? (1 << ecol) : 0);
      chk(trigger == etrig, ctx, {"R7 trigger ", utag}, int'(trigger), int'(etrig));
      if (t == chg_at) begin
        cfg_frame_cycles = 24'd999;
        cfg_share_r = 7'd90; cfg_share_g = 7'd5; cfg_share_b = 7'd5;
        cfg_trig_len = 8'd7;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(color_idx == '0 && bit_idx == '0 && !plane_valid && !load_strobe && led_en == '0 && !trigger,
        "reset", "R1", int'({color_idx, bit_idx, plane_valid, load_strobe, led_en, trigger}), 0);
    rst_n = 1'b1;
    cfg_frame_cycles = 24'd3000; cfg_share_r = 7'd40; cfg_share_g = 7'd45; cfg_share_b = 7'd15;
    cfg_trig_len = 8'd3;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(color_idx == '0 && !plane_valid && !load_strobe && led_en == '0 && !trigger,
          "idle before frame", "R1",
          int'({color_idx, bit_idx, plane_valid, load_strobe, led_en, trigger}), 0);
    end
    // Table walk
    for (int i = 0; i < NV; i++) begin
      int tot;
      tot = (int'(VECS[i].fc) * int'(VECS[i].sr)) / 100 + (int'(VECS[i].fc) * int'(VECS[i].sg)) / 100
          + (int'(VECS[i].fc) * int'(VECS[i].sb)) / 100;
      run_frame(VECS[i], tot + 6, -1, "table");
    end
    // R8: configuration changed mid-frame must not alter this frame
    run_frame(VECS[0], 3006, 50, "R8 midframe cfg");
    // R9: frame start in the middle of a frame
    run_frame(VECS[1], 700, -1, "R9 pre");
    run_frame(VECS[0], 3006, -1, "R9 resync");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule